// File: doc/BRIEF.md
# Ethernet MAC Register and Descriptor Window Slave

This block is the software-facing register file of an Ethernet MAC. A 32-bit word bus reaches a set of configuration registers (operating mode, frame length limits, inter-packet gaps, collision settings, management-port registers, the 48-bit station address) and a window onto the descriptor RAM. The TX and RX descriptor engines read their configuration from the exported fields, read descriptor words through a private read port, write status back into descriptor RAM and raise interrupt events. The block combines those events with a mask into a single interrupt line.

Each bus access is a single-cycle request (`req_valid` with `req_write`, `req_addr`, `req_wdata`). The reply appears exactly one cycle later on `resp_valid`, with `resp_rdata` and `resp_error`. A small two-state machine handles the reply. `ST_IDLE` means no reply is pending and `ST_RESP` means a reply is being presented. `req_valid` moves `ST_IDLE` to `ST_RESP`. `ST_RESP` stays in `ST_RESP` on another request and returns to `ST_IDLE` when none arrives. A new request is therefore taken every cycle. Writes and rejected accesses reply with zero data.

The register layout, in byte offsets, is as follows.

| Offset | Register | Reset value |
|---|---|---|
| 0x00 | mode | 0x0000A000 |
| 0x04 | frame length | 0x003C0600 |
| 0x08 | interrupt source | 0 |
| 0x0C | interrupt mask | 0 |
| 0x10 | descriptor count | 0x80 |
| 0x14 | station address low | 0 |
| 0x18 | station address high | 0 |
| 0x1C | back-to-back gap | 0x12 |
| 0x20 | gap part 1 | 0x0C |
| 0x24 | gap part 2 | 0x12 |
| 0x28 | collision config | 0x000F003F |
| 0x2C | control mode | 0 |
| 0x30 | management mode | 0x64 |
| 0x34 | management command | 0 |
| 0x38 | management address | 0 |
| 0x3C | management write data | 0 |
| 0x40 | management read data | 0 |
| 0x44 | management status | 0 |

The descriptor window starts at 0x400 and spans 256 words.

Top module: `mac_reg_slave`

## Requirements
- R1: After reset, reads return the reset values in the layout table above. Descriptor RAM words read zero.
- R2: `pkt_min_len` equals bits 31:16 of the frame-length register and `pkt_max_len` equals bits 15:0. After reset they are 60 and 1536.
- R3: A write to the descriptor-count register keeps only bits 7:0. It drives that value on both `tx_bd_count` and `rx_bd_ptr` from the next cycle on. A readback returns the 8-bit value.
- R4: Bytes 0..3 of the station address are written from bits 7:0..31:24 of the low register. Bytes 4 and 5 are written from bits 7:0 and 15:8 of the high register. The high register reads back only bits 15:0. `station_addr` carries byte k at bits 8k+7:8k.
- R5: An aligned access at offset A with 0x400 <= A < 0x800 reaches descriptor word (A-0x400)/4. That word is also visible on `bd_rd_data` when `bd_rd_idx` selects it.
- R6: An access whose offset has bits 1:0 non-zero gets `resp_error`=1 and zero data, and changes no state.
- R7: An aligned access to an offset outside the table and outside the window gets `resp_error`=1, and a read returns zero.
- R8: Writing the interrupt-source register clears each bit written as 1. A bit requested by `int_set` in the same cycle stays set, because a set request wins over a clear.
- R9: `irq` is high exactly when some interrupt-source bit and the matching mask bit are both 1.
- R10: Each request cycle is followed by exactly one cycle with `resp_valid`=1. Without a request, `resp_valid` stays 0.
- R11: `bd_wb_en` writes `bd_wb_data` into descriptor word `bd_wb_idx`. If a bus write hits the same word in the same cycle, the engine's writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset from the block base |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Reply strobe, one cycle after the request |
| resp_rdata | output | 32 | Read data (zero for writes and errors) |
| resp_error | output | 1 | Misaligned or unmapped access |
| int_set | input | 7 | Per-bit interrupt event requests from the engines |
| irq | output | 1 | Masked interrupt line |
| mode_cfg | output | 32 | Mode register contents |
| pkt_min_len | output | 16 | Minimum frame length |
| pkt_max_len | output | 16 | Maximum frame length |
| tx_bd_count | output | 8 | Number of TX descriptors |
| rx_bd_ptr | output | 8 | RX descriptor pointer |
| station_addr | output | 48 | Station address, byte k at bits 8k+7:8k |
| bd_rd_idx | input | 8 | Engine descriptor read index |
| bd_rd_data | output | 32 | Engine descriptor read data |
| bd_wb_en | input | 1 | Engine descriptor writeback strobe |
| bd_wb_idx | input | 8 | Writeback word index |
| bd_wb_data | input | 32 | Writeback data |

## Verification
Two collisions can happen in the same cycle, and both are provoked on purpose. In the first, a bus write to the interrupt-source register clears a bit while an engine raises that same bit. The bench drives both on one edge, then reads the register back; the bit must still be set (R8). In the second, a bus write to a descriptor word lands in the same cycle as an engine writeback to the same index; the readback must show the engine's data (R11). For contrast, a clear with no competing set is also checked, and it must take effect.

// File: rtl/mac_regs_pkg.sv
package mac_regs_pkg;

    localparam int OFF_MODE    = 'h00;
    localparam int OFF_FRLEN   = 'h04;
    localparam int OFF_ISRC    = 'h08;
    localparam int OFF_IMASK   = 'h0C;
    localparam int OFF_BDCNT   = 'h10;
    localparam int OFF_SA_LO   = 'h14;
    localparam int OFF_SA_HI   = 'h18;
    localparam int OFF_GAP_B2B = 'h1C;
    localparam int OFF_GAP_1   = 'h20;
    localparam int OFF_GAP_2   = 'h24;
    localparam int OFF_COLL    = 'h28;
    localparam int OFF_CTRL    = 'h2C;
    localparam int OFF_MG_MODE = 'h30;
    localparam int OFF_MG_CMD  = 'h34;
    localparam int OFF_MG_ADDR = 'h38;
    localparam int OFF_MG_WDAT = 'h3C;
    localparam int OFF_MG_RDAT = 'h40;
    localparam int OFF_MG_STAT = 'h44;

    localparam logic [31:0] RST_MODE    = 32'h0000_A000;
    localparam logic [31:0] RST_FRLEN   = 32'h003C_0600;
    localparam logic [31:0] RST_GAP_B2B = 32'h0000_0012;
    localparam logic [31:0] RST_GAP_1   = 32'h0000_000C;
    localparam logic [31:0] RST_GAP_2   = 32'h0000_0012;
    localparam logic [31:0] RST_COLL    = 32'h000F_003F;
    localparam logic [31:0] RST_MG_MODE = 32'h0000_0064;
    localparam logic [7:0]  RST_BDCNT   = 8'h80;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_MODE, SEL_FRLEN, SEL_ISRC, SEL_IMASK, SEL_BDCNT,
        SEL_SA_LO, SEL_SA_HI, SEL_GAP_B2B, SEL_GAP_1, SEL_GAP_2, SEL_COLL,
        SEL_CTRL, SEL_MG_MODE, SEL_MG_CMD, SEL_MG_ADDR, SEL_MG_WDAT,
        SEL_MG_RDAT, SEL_MG_STAT, SEL_BD
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } slv_state_e;

endpackage

// File: rtl/mac_reg_decode.sv
module mac_reg_decode
    import mac_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BD_BASE  = 'h400,
    parameter int BD_WORDS = 256,
    parameter int BD_IDX_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_sel_e            sel,
    output logic                misaligned,
    output logic [BD_IDX_W-1:0] bd_idx
);
    localparam int BD_END = BD_BASE + BD_WORDS * 4;

    logic [31:0] a32;
    logic [31:0] rel;
    logic        in_win;

    always_comb begin
        a32        = 32'(addr);
        rel        = a32 - 32'(BD_BASE);
        in_win     = (a32 >= 32'(BD_BASE)) && (a32 < 32'(BD_END));
        misaligned = (addr[1:0] != 2'b00);
        bd_idx     = BD_IDX_W'(rel >> 2);
        sel        = SEL_NONE;
        if (!misaligned) begin
            if (in_win) begin
                sel = SEL_BD;
            end else begin
                case (a32)
                    32'(OFF_MODE):    sel = SEL_MODE;
                    32'(OFF_FRLEN):   sel = SEL_FRLEN;
                    32'(OFF_ISRC):    sel = SEL_ISRC;
                    32'(OFF_IMASK):   sel = SEL_IMASK;
                    32'(OFF_BDCNT):   sel = SEL_BDCNT;
                    32'(OFF_SA_LO):   sel = SEL_SA_LO;
                    32'(OFF_SA_HI):   sel = SEL_SA_HI;
                    32'(OFF_GAP_B2B): sel = SEL_GAP_B2B;
                    32'(OFF_GAP_1):   sel = SEL_GAP_1;
                    32'(OFF_GAP_2):   sel = SEL_GAP_2;
                    32'(OFF_COLL):    sel = SEL_COLL;
                    32'(OFF_CTRL):    sel = SEL_CTRL;
                    32'(OFF_MG_MODE): sel = SEL_MG_MODE;
                    32'(OFF_MG_CMD):  sel = SEL_MG_CMD;
                    32'(OFF_MG_ADDR): sel = SEL_MG_ADDR;
                    32'(OFF_MG_WDAT): sel = SEL_MG_WDAT;
                    32'(OFF_MG_RDAT): sel = SEL_MG_RDAT;
                    32'(OFF_MG_STAT): sel = SEL_MG_STAT;
                    default:          sel = SEL_NONE;
                endcase
            end
        end
    end

    // R6: a misaligned offset never selects a target
    always_comb begin
        p_misalign_nosel_r6: assert (!(misaligned && sel != SEL_NONE));
    end

endmodule

// File: rtl/mac_bd_ram.sv
module mac_bd_ram #(
    parameter int BD_WORDS = 256,
    parameter int BD_IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [BD_IDX_W-1:0] bus_idx,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [BD_IDX_W-1:0] eng_rd_idx,
    output logic [31:0]         eng_rd_data,
    input  logic                wb_en,
    input  logic [BD_IDX_W-1:0] wb_idx,
    input  logic [31:0]         wb_data
);
    logic [31:0] words_q [BD_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BD_WORDS; i++) words_q[i] <= '0;
        end else begin
            if (bus_we) words_q[bus_idx] <= bus_wdata;
            // engine status writeback is applied last so it wins a same-word collision
            if (wb_en)  words_q[wb_idx]  <= wb_data;
        end
    end

    assign bus_rdata   = words_q[bus_idx];
    assign eng_rd_data = words_q[eng_rd_idx];

    p_writeback_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> words_q[$past(wb_idx)] == $past(wb_data));

endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit #(
    parameter int INT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [INT_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [INT_W-1:0] mask_wdata,
    input  logic [INT_W-1:0] int_set,
    output logic [INT_W-1:0] src_q,
    output logic [INT_W-1:0] mask_q,
    output logic             irq
);
    logic [INT_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q <= (src_q & ~clr_eff) | int_set;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq = |(src_q & mask_q);

    // R8: a set request survives any clear issued in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_set) |=> ((src_q & $past(int_set)) == $past(int_set)));

    // R9: an enabled event raises the line on the next cycle
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(int_set & mask_q) && !mask_we) |=> irq);

endmodule

// File: rtl/mac_reg_slave.sv
module mac_reg_slave
    import mac_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BD_BASE  = 'h400,
    parameter int BD_WORDS = 256,
    parameter int INT_W    = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          resp_valid,
    output logic [31:0]                   resp_rdata,
    output logic                          resp_error,
    input  logic [INT_W-1:0]              int_set,
    output logic                          irq,
    output logic [31:0]                   mode_cfg,
    output logic [15:0]                   pkt_min_len,
    output logic [15:0]                   pkt_max_len,
    output logic [7:0]                    tx_bd_count,
    output logic [7:0]                    rx_bd_ptr,
    output logic [47:0]                   station_addr,
    input  logic [$clog2(BD_WORDS)-1:0]   bd_rd_idx,
    output logic [31:0]                   bd_rd_data,
    input  logic                          bd_wb_en,
    input  logic [$clog2(BD_WORDS)-1:0]   bd_wb_idx,
    input  logic [31:0]                   bd_wb_data
);
    localparam int BD_IDX_W = $clog2(BD_WORDS);

    reg_sel_e            sel;
    logic                misaligned;
    logic [BD_IDX_W-1:0] bd_idx;
    logic                acc_err;
    logic                wr_ok;
    logic [31:0]         rd_mux;
    logic [31:0]         bd_bus_rdata;
    logic [INT_W-1:0]    src_q;
    logic [INT_W-1:0]    mask_q;

    slv_state_e state_q, state_d;
    logic [31:0] rdata_q;
    logic        err_q;

    logic [31:0] mode_q, frlen_q, gap_b2b_q, gap1_q, gap2_q, coll_q, ctrl_q;
    logic [31:0] mg_mode_q, mg_cmd_q, mg_addr_q, mg_wdat_q, mg_rdat_q, mg_stat_q;
    logic [31:0] sa_lo_q;
    logic [15:0] sa_hi_q;
    logic [7:0]  bdcnt_q, rxptr_q;

    mac_reg_decode #(
        .ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS), .BD_IDX_W(BD_IDX_W)
    ) u_dec (
        .addr(req_addr), .sel(sel), .misaligned(misaligned), .bd_idx(bd_idx)
    );

    assign acc_err = (sel == SEL_NONE);
    assign wr_ok   = req_valid && req_write && !acc_err;

    mac_bd_ram #(.BD_WORDS(BD_WORDS), .BD_IDX_W(BD_IDX_W)) u_bd (
        .clk(clk), .rst_n(rst_n),
        .bus_we(wr_ok && sel == SEL_BD), .bus_idx(bd_idx), .bus_wdata(req_wdata),
        .bus_rdata(bd_bus_rdata),
        .eng_rd_idx(bd_rd_idx), .eng_rd_data(bd_rd_data),
        .wb_en(bd_wb_en), .wb_idx(bd_wb_idx), .wb_data(bd_wb_data)
    );

    mac_irq_unit #(.INT_W(INT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .clr_we(wr_ok && sel == SEL_ISRC), .clr_bits(req_wdata[INT_W-1:0]),
        .mask_we(wr_ok && sel == SEL_IMASK), .mask_wdata(req_wdata[INT_W-1:0]),
        .int_set(int_set), .src_q(src_q), .mask_q(mask_q), .irq(irq)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= RST_MODE;
            frlen_q   <= RST_FRLEN;
            gap_b2b_q <= RST_GAP_B2B;
            gap1_q    <= RST_GAP_1;
            gap2_q    <= RST_GAP_2;
            coll_q    <= RST_COLL;
            ctrl_q    <= '0;
            mg_mode_q <= RST_MG_MODE;
            mg_cmd_q  <= '0;
            mg_addr_q <= '0;
            mg_wdat_q <= '0;
            mg_rdat_q <= '0;
            mg_stat_q <= '0;
            sa_lo_q   <= '0;
            sa_hi_q   <= '0;
            bdcnt_q   <= RST_BDCNT;
            rxptr_q   <= RST_BDCNT;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_MODE:    mode_q    <= req_wdata;
                SEL_FRLEN:   frlen_q   <= req_wdata;
                SEL_GAP_B2B: gap_b2b_q <= req_wdata;
                SEL_GAP_1:   gap1_q    <= req_wdata;
                SEL_GAP_2:   gap2_q    <= req_wdata;
                SEL_COLL:    coll_q    <= req_wdata;
                SEL_CTRL:    ctrl_q    <= req_wdata;
                SEL_MG_MODE: mg_mode_q <= req_wdata;
                SEL_MG_CMD:  mg_cmd_q  <= req_wdata;
                SEL_MG_ADDR: mg_addr_q <= req_wdata;
                SEL_MG_WDAT: mg_wdat_q <= req_wdata;
                SEL_MG_RDAT: mg_rdat_q <= req_wdata;
                SEL_MG_STAT: mg_stat_q <= req_wdata;
                SEL_SA_LO:   sa_lo_q   <= req_wdata;
                SEL_SA_HI:   sa_hi_q   <= req_wdata[15:0];
                SEL_BDCNT: begin
                    bdcnt_q <= req_wdata[7:0];
                    rxptr_q <= req_wdata[7:0];
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        unique case (sel)
            SEL_MODE:    rd_mux = mode_q;
            SEL_FRLEN:   rd_mux = frlen_q;
            SEL_ISRC:    rd_mux = 32'(src_q);
            SEL_IMASK:   rd_mux = 32'(mask_q);
            SEL_BDCNT:   rd_mux = 32'(bdcnt_q);
            SEL_SA_LO:   rd_mux = sa_lo_q;
            SEL_SA_HI:   rd_mux = 32'(sa_hi_q);
            SEL_GAP_B2B: rd_mux = gap_b2b_q;
            SEL_GAP_1:   rd_mux = gap1_q;
            SEL_GAP_2:   rd_mux = gap2_q;
            SEL_COLL:    rd_mux = coll_q;
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_MG_MODE: rd_mux = mg_mode_q;
            SEL_MG_CMD:  rd_mux = mg_cmd_q;
            SEL_MG_ADDR: rd_mux = mg_addr_q;
            SEL_MG_WDAT: rd_mux = mg_wdat_q;
            SEL_MG_RDAT: rd_mux = mg_rdat_q;
            SEL_MG_STAT: rd_mux = mg_stat_q;
            SEL_BD:      rd_mux = bd_bus_rdata;
            default:     rd_mux = '0;
        endcase
    end

    // reply state machine: state register
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                rdata_q <= (req_write || acc_err) ? 32'h0 : rd_mux;
                err_q   <= acc_err;
            end
        end
    end

    // reply state machine: outputs
    always_comb begin
        resp_valid = (state_q == ST_RESP);
        resp_rdata = resp_valid ? rdata_q : 32'h0;
        resp_error = resp_valid && err_q;
    end

    assign mode_cfg     = mode_q;
    assign pkt_min_len  = frlen_q[31:16];
    assign pkt_max_len  = frlen_q[15:0];
    assign tx_bd_count  = bdcnt_q;
    assign rx_bd_ptr    = rxptr_q;
    assign station_addr = {sa_hi_q, sa_lo_q};

    p_reply_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_no_spurious_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    p_error_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_error |-> resp_rdata == 32'h0);
    p_misalign_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misaligned) |=> resp_error);
    p_count_loads_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == SEL_BDCNT) |=>
            (rx_bd_ptr == $past(req_wdata[7:0]) && tx_bd_count == $past(req_wdata[7:0])));
    p_station_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && (sel == SEL_SA_LO || sel == SEL_SA_HI)) |=> $stable(station_addr));

endmodule

// File: tb/mac_reg_slave_test.sv
module mac_reg_slave_test;
    localparam int NV = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_error, irq;
    logic [31:0] resp_rdata, mode_cfg, bd_rd_data;
    logic [6:0]  int_set = '0;
    logic [15:0] pkt_min_len, pkt_max_len;
    logic [7:0]  tx_bd_count, rx_bd_ptr, bd_rd_idx = '0, bd_wb_idx = '0;
    logic [47:0] station_addr;
    logic        bd_wb_en = 1'b0;
    logic [31:0] bd_wb_data = '0;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    mac_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .resp_error(resp_error), .int_set(int_set), .irq(irq),
        .mode_cfg(mode_cfg), .pkt_min_len(pkt_min_len), .pkt_max_len(pkt_max_len),
        .tx_bd_count(tx_bd_count), .rx_bd_ptr(rx_bd_ptr), .station_addr(station_addr),
        .bd_rd_idx(bd_rd_idx), .bd_rd_data(bd_rd_data), .bd_wb_en(bd_wb_en),
        .bd_wb_idx(bd_wb_idx), .bd_wb_data(bd_wb_data)
    );

    // {write, addr, wdata, expected data, expected error}, requirement tag
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0, 32'h0000A000, 1'b0},   // R1
        {1'b0, 12'h004, 32'h0, 32'h003C0600, 1'b0},   // R1
        {1'b0, 12'h008, 32'h0, 32'h00000000, 1'b0},   // R1
        {1'b0, 12'h00C, 32'h0, 32'h00000000, 1'b0},   // R1
        {1'b0, 12'h010, 32'h0, 32'h00000080, 1'b0},   // R1
        {1'b0, 12'h014, 32'h0, 32'h00000000, 1'b0},   // R1
        {1'b0, 12'h01C, 32'h0, 32'h00000012, 1'b0},   // R1
        {1'b0, 12'h020, 32'h0, 32'h0000000C, 1'b0},   // R1
        {1'b0, 12'h024, 32'h0, 32'h00000012, 1'b0},   // R1
        {1'b0, 12'h028, 32'h0, 32'h000F003F, 1'b0},   // R1
        {1'b0, 12'h030, 32'h0, 32'h00000064, 1'b0},   // R1
        {1'b0, 12'h044, 32'h0, 32'h00000000, 1'b0},   // R1
        {1'b0, 12'h7FC, 32'h0, 32'h00000000, 1'b0},   // R1
        {1'b1, 12'h014, 32'h44332211, 32'h0, 1'b0},   // R4
        {1'b1, 12'h018, 32'hFFFF6655, 32'h0, 1'b0},   // R4
        {1'b0, 12'h018, 32'h0, 32'h00006655, 1'b0},   // R4
        {1'b0, 12'h014, 32'h0, 32'h44332211, 1'b0},   // R4
        {1'b1, 12'h010, 32'h00001234, 32'h0, 1'b0},   // R3
        {1'b0, 12'h010, 32'h0, 32'h00000034, 1'b0},   // R3
        {1'b1, 12'h004, 32'h00400500, 32'h0, 1'b0},   // R2
        {1'b1, 12'h404, 32'hDEADBEEF, 32'h0, 1'b0},   // R5
        {1'b0, 12'h404, 32'h0, 32'hDEADBEEF, 1'b0},   // R5
        {1'b0, 12'h400, 32'h0, 32'h00000000, 1'b0},   // R5
        {1'b1, 12'h002, 32'h12345678, 32'h0, 1'b1},   // R6
        {1'b1, 12'h406, 32'h12345678, 32'h0, 1'b1},   // R6
        {1'b0, 12'h001, 32'h0, 32'h00000000, 1'b1},   // R6
        {1'b0, 12'h000, 32'h0, 32'h0000A000, 1'b0},   // R6 mode untouched
        {1'b0, 12'h048, 32'h0, 32'h00000000, 1'b1},   // R7
        {1'b0, 12'h800, 32'h0, 32'h00000000, 1'b1},   // R7
        {1'b1, 12'h3FC, 32'hFFFFFFFF, 32'h0, 1'b1}    // R7
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drives one request at a falling edge and samples the reply at the next falling edge
    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(resp_valid === 1'b1, "R10", 64'(resp_valid), 64'd1);
        rd = resp_rdata;
        er = resp_error;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid === 1'b0, "R10", 64'(resp_valid), 64'd0);
        check(pkt_min_len == 16'd60 && pkt_max_len == 16'd1536, "R2",
              {pkt_min_len, pkt_max_len}, {16'd60, 16'd1536});
        check(irq === 1'b0, "R9", 64'(irq), 64'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][77], VEC[i][76:65], VEC[i][64:33], rd, er);
            check(rd === VEC[i][32:1] && er === VEC[i][0], $sformatf("table entry %0d", i),
                  {rd, 31'd0, er}, {VEC[i][32:1], 31'd0, VEC[i][0]});
        end

        // exported fields after the table
        check(station_addr == 48'h665544332211, "R4", 64'(station_addr), 64'h665544332211);
        check(tx_bd_count == 8'h34 && rx_bd_ptr == 8'h34, "R3",
              {tx_bd_count, rx_bd_ptr}, 16'h3434);
        check(pkt_min_len == 16'h0040 && pkt_max_len == 16'h0500, "R2",
              {pkt_min_len, pkt_max_len}, 32'h00400500);
        bd_rd_idx = 8'd1;
        #1;
        check(bd_rd_data == 32'hDEADBEEF, "R5", 64'(bd_rd_data), 64'hDEADBEEF);
        check(mode_cfg == 32'h0000A000, "R6", 64'(mode_cfg), 64'hA000);

        // R9: an event with mask clear leaves irq low
        @(negedge clk); int_set = 7'h04;
        @(negedge clk); int_set = 7'h00;
        check(irq === 1'b0, "R9", 64'(irq), 64'd0);
        access(1'b1, 12'h00C, 32'h0000007F, rd, er);
        check(irq === 1'b1, "R9", 64'(irq), 64'd1);
        access(1'b0, 12'h008, 32'h0, rd, er);
        check(rd == 32'h4, "R8", 64'(rd), 64'h4);
        // R8: plain clear
        access(1'b1, 12'h008, 32'h00000004, rd, er);
        access(1'b0, 12'h008, 32'h0, rd, er);
        check(rd == 32'h0 && irq === 1'b0, "R8", {rd, 31'd0, irq}, 64'h0);
        // R8: clear and set of bit 1 in the same cycle
        @(negedge clk); int_set = 7'h02;
        @(negedge clk); int_set = 7'h00;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h008; req_wdata = 32'h2; int_set = 7'h02;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; int_set = 7'h00;
        access(1'b0, 12'h008, 32'h0, rd, er);
        check(rd == 32'h2, "R8", 64'(rd), 64'h2);

        // R11: bus write and engine writeback hit word 5 together
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h414; req_wdata = 32'h11111111;
        bd_wb_en = 1'b1; bd_wb_idx = 8'd5; bd_wb_data = 32'hCAFEF00D;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; bd_wb_en = 1'b0;
        access(1'b0, 12'h414, 32'h0, rd, er);
        check(rd == 32'hCAFEF00D, "R11", 64'(rd), 64'hCAFEF00D);
        // R11: writeback alone, seen on the bus window
        @(negedge clk); bd_wb_en = 1'b1; bd_wb_idx = 8'd255; bd_wb_data = 32'h0BADC0DE;
        @(negedge clk); bd_wb_en = 1'b0;
        access(1'b0, 12'h7FC, 32'h0, rd, er);
        check(rd == 32'h0BADC0DE, "R11", 64'(rd), 64'h0BADC0DE);

        @(negedge clk);
        check(resp_valid === 1'b0, "R10", 64'(resp_valid), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule